// File: doc/BRIEF.md
# Strobed Input Port with Handshake

This block is an 8-bit peripheral input port. An external device places a byte on the data pins and pulses an active-low strobe. When the strobe returns high, the byte is loaded into an input latch. A buffer-full flag then tells both the host and the peripheral that a byte is waiting. A maskable interrupt request can also notify the host. The strobe and the data pins are brought into the system clock domain through matched register pipelines. Because the two pipelines have the same depth, the captured byte is exactly the one that was present while the strobe was low.

The host has a small synchronous register interface. A data read returns the latch contents and releases the handshake, which clears buffer-full and drops the interrupt. A status read returns the flags and the two spare input pins without disturbing anything. Single-bit set/reset commands do two jobs: they set or clear the internal interrupt-enable bit, and they drive the two spare output pins. The position of the enable bit depends on whether the port is instanced as the first group or the second group.

Top module: `strobed_inport`

## Requirements
- R1: After a synchronous active-high reset, all of the following are 0: the latch, `ibf`, `intr`, the interrupt enable, `spare_out` and `host_rdata`.
- R2: The latch loads on the low-to-high transition of `stb_n`. It takes the `pin_data` value that was present while `stb_n` was low. A change of `pin_data` at or after the rising transition of the strobe does not change the latch.
- R3: `ibf` goes to 1 at the third rising clock edge after `stb_n` rises (SYNC_STAGES=2 plus one edge-detect register). It stays at 1 until a data read.
- R4: A data read (`host_rd`=1, `host_sel`=0) puts the latch contents on `host_rdata` at the next clock edge. The same edge clears `ibf` and `intr`.
- R5: `intr` is a register that is 1 exactly when the synchronized strobe is high, `ibf` is 1 and the interrupt enable is 1.
- R6: A set/reset command is `host_wr`=1 with `host_wdata[7]`=0. `host_wdata[3:1]` selects the bit and `host_wdata[0]` is the new value. Index 4 (when GROUP_B=0) or index 2 (when GROUP_B=1) writes the interrupt enable.
- R7: Index 7 writes `spare_out[1]` and index 6 writes `spare_out[0]`.
- R8: A write with `host_wdata[7]`=1 has no effect, and neither does a command to any other index. A status read does not clear `ibf`.
- R9: A status read (`host_sel`=1) returns the following byte on `host_rdata` at the next edge. When GROUP_B=0: bit 7 = `spare_in[1]`, bit 6 = `spare_in[0]`, bit 5 = `ibf`, bit 4 = enable, bit 3 = `intr`. When GROUP_B=1, `ibf`, enable and `intr` move to bits 1, 2 and 0. All other bits read 0.
- R10: A second strobe while `ibf` is set replaces the latch contents with the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| stb_n | input | 1 | Asynchronous active-low load strobe from the peripheral |
| pin_data | input | 8 | Peripheral data pins |
| host_rd | input | 1 | Host read request, one cycle |
| host_sel | input | 1 | Read target: 0 data latch, 1 status byte |
| host_wr | input | 1 | Host write of a bit set/reset command |
| host_wdata | input | 8 | Command byte |
| host_rdata | output | 8 | Registered read data |
| ibf | output | 1 | Input buffer full |
| intr | output | 1 | Interrupt request |
| spare_in | input | 2 | General-purpose input pins |
| spare_out | output | 2 | General-purpose output pins |

## Verification
Suppose the synchronizer or the edge detector keeps the wrong state. Then `ibf` rises one edge early or late, or not at all, and the exact-cycle check after a strobe release exposes this within three clocks. A stale or misaligned data pipeline shows up as the wrong byte on the next data read. This includes the byte changed at the moment of release. A bad enable bit or a bad spare-pin register appears at `intr`, `spare_out` or the status byte on the clock after the command. A buffer-full flag that fails to clear shows on the cycle after a data read.

// File: rtl/inport_pkg.sv
package inport_pkg;

  typedef struct packed {
    logic       is_bsr;
    logic [2:0] idx;
    logic       val;
  } bsr_cmd_t;

  function automatic bsr_cmd_t decode_bsr(input logic wr, input logic [7:0] w);
    bsr_cmd_t c;
    c.is_bsr = wr & ~w[7];
    c.idx    = w[3:1];
    c.val    = w[0];
    return c;
  endfunction

endpackage

// File: rtl/inport_sync.sv
module inport_sync #(
  parameter int STAGES = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb_n,
  input  logic [DATA_W-1:0] pin_data,
  output logic              stb_hi,
  output logic              rise,
  output logic [DATA_W-1:0] data_al
);

  logic [STAGES-1:0] sreg;
  logic [DATA_W-1:0] dpipe [STAGES];
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '1;
      prev <= 1'b1;
    end else begin
      sreg <= {sreg[STAGES-2:0], stb_n};
      prev <= sreg[STAGES-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dpipe[0] <= '0;
    else     dpipe[0] <= pin_data;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_dpipe
    always_ff @(posedge clk) begin
      if (rst) dpipe[g] <= '0;
      else     dpipe[g] <= dpipe[g-1];
    end
  end

  assign stb_hi  = sreg[STAGES-1];
  assign rise    = stb_hi & ~prev;
  assign data_al = dpipe[STAGES-1];

endmodule

// File: rtl/inport_latch.sv
module inport_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb_hi,
  input  logic              rise,
  input  logic [DATA_W-1:0] data_al,
  input  logic              rd_clr,
  output logic [DATA_W-1:0] latch,
  output logic              ibf,
  output logic              ibf_nxt
);

  logic [DATA_W-1:0] stage;

  always_comb begin
    ibf_nxt = ibf;
    if (rd_clr) ibf_nxt = 1'b0;
    if (rise)   ibf_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '0;
      latch <= '0;
      ibf   <= 1'b0;
    end else begin
      if (!stb_hi) stage <= data_al;
      if (rise)    latch <= stage;
      ibf <= ibf_nxt;
    end
  end

  p_capture_sets_ibf_r3: assert property (@(posedge clk) disable iff (rst)
    rise |=> ibf && (latch == $past(stage)));
  p_latch_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(latch));
  p_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !rise) |=> !ibf);

endmodule

// File: rtl/inport_ctrl.sv
module inport_ctrl
  import inport_pkg::*;
#(
  parameter bit GROUP_B = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       inte,
  output logic       inte_nxt,
  output logic [1:0] spare_out
);

  localparam logic [2:0] EN_IDX = GROUP_B ? 3'd2 : 3'd4;

  bsr_cmd_t cmd;
  logic [1:0] spare_nxt;

  always_comb begin
    cmd       = decode_bsr(wr, wdata);
    inte_nxt  = inte;
    spare_nxt = spare_out;
    if (cmd.is_bsr) begin
      if (cmd.idx == EN_IDX) inte_nxt     = cmd.val;
      if (cmd.idx == 3'd7)   spare_nxt[1] = cmd.val;
      if (cmd.idx == 3'd6)   spare_nxt[0] = cmd.val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inte      <= 1'b0;
      spare_out <= 2'b00;
    end else begin
      inte      <= inte_nxt;
      spare_out <= spare_nxt;
    end
  end

  p_mode_word_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (wr && wdata[7]) |=> $stable(inte) && $stable(spare_out));
  p_enable_write_r6: assert property (@(posedge clk) disable iff (rst)
    (wr && !wdata[7] && wdata[3:1] == EN_IDX) |=> inte == $past(wdata[0]));

endmodule

// File: rtl/strobed_inport.sv
module strobed_inport #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit GROUP_B     = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb_n,
  input  logic [DATA_W-1:0] pin_data,
  input  logic              host_rd,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [7:0]        host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              ibf,
  output logic              intr,
  input  logic [1:0]        spare_in,
  output logic [1:0]        spare_out
);

  localparam int IBF_POS  = GROUP_B ? 1 : 5;
  localparam int INTE_POS = GROUP_B ? 2 : 4;
  localparam int INTR_POS = GROUP_B ? 0 : 3;

  logic              stb_hi, rise, ibf_nxt, inte, inte_nxt, rd_clr;
  logic [DATA_W-1:0] data_al, latch;
  logic [7:0]        status;

  assign rd_clr = host_rd & ~host_sel;

  inport_sync #(.STAGES(SYNC_STAGES), .DATA_W(DATA_W)) u_sync (
    .clk(clk), .rst(rst), .stb_n(stb_n), .pin_data(pin_data),
    .stb_hi(stb_hi), .rise(rise), .data_al(data_al)
  );

  inport_latch #(.DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst(rst), .stb_hi(stb_hi), .rise(rise), .data_al(data_al),
    .rd_clr(rd_clr), .latch(latch), .ibf(ibf), .ibf_nxt(ibf_nxt)
  );

  inport_ctrl #(.GROUP_B(GROUP_B)) u_ctrl (
    .clk(clk), .rst(rst), .wr(host_wr), .wdata(host_wdata),
    .inte(inte), .inte_nxt(inte_nxt), .spare_out(spare_out)
  );

  always_comb begin
    status           = 8'h00;
    status[7]        = spare_in[1];
    status[6]        = spare_in[0];
    status[IBF_POS]  = ibf;
    status[INTE_POS] = inte;
    status[INTR_POS] = intr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      intr       <= 1'b0;
      host_rdata <= '0;
    end else begin
      intr <= stb_hi & ibf_nxt & inte_nxt;
      if (host_rd) host_rdata <= host_sel ? DATA_W'(status) : latch;
    end
  end

  p_intr_gated_r5: assert property (@(posedge clk) disable iff (rst)
    intr |-> ibf && inte);
  p_read_data_r4: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_sel) |=> host_rdata == $past(latch));
  p_read_drops_intr_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !rise) |=> !intr);

endmodule

// File: tb/sim_strobed_inport.sv
module sim_strobed_inport;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stb_n = 1'b1;
  logic [7:0] pin_data = 8'h00;
  logic       host_rd = 1'b0, host_sel = 1'b0, host_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       ibf, intr;
  logic [1:0] spare_in = 2'b00, spare_out;

  int checks = 0, errors = 0;
  logic [7:0] m_latch = 8'h00;
  logic       m_ibf = 1'b0, m_inte = 1'b0;
  logic [1:0] m_spare = 2'b00;
  bit done = 1'b0;

  always #4 clk = ~clk;

  strobed_inport u0 (
    .clk(clk), .rst(rst), .stb_n(stb_n), .pin_data(pin_data),
    .host_rd(host_rd), .host_sel(host_sel), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .ibf(ibf),
    .intr(intr), .spare_in(spare_in), .spare_out(spare_out)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status(input logic [1:0] sp, input logic b,
                                            input logic e, input logic q);
    return {sp[1], sp[0], b, e, q, 3'b000};
  endfunction

  task automatic do_strobe(input logic [7:0] d, input string req);
    pin_data = d; stb_n = 1'b0;
    repeat (4) tick();
    stb_n = 1'b1; pin_data = ~d;
    repeat (4) tick();
    m_latch = d; m_ibf = 1'b1;
    check(ibf == 1'b1, req, ibf, 1);
    check(intr == m_inte, "R5", intr, m_inte);
  endtask

  task automatic do_read(input string req);
    host_rd = 1'b1; host_sel = 1'b0;
    tick();
    host_rd = 1'b0;
    check(host_rdata == m_latch, req, host_rdata, m_latch);
    check(ibf == 1'b0 && intr == 1'b0, "R4", {ibf, intr}, 0);
    m_ibf = 1'b0;
  endtask

  task automatic do_status(input string req);
    logic [7:0] e;
    spare_in = 2'($urandom);
    e = exp_status(spare_in, m_ibf, m_inte, m_ibf & m_inte);
    host_rd = 1'b1; host_sel = 1'b1;
    tick();
    host_rd = 1'b0; host_sel = 1'b0;
    check(host_rdata == e, req, host_rdata, e);
    check(ibf == m_ibf, "R8", ibf, m_ibf);
  endtask

  task automatic do_bsr(input logic [7:0] w, input string req);
    host_wr = 1'b1; host_wdata = w;
    tick();
    host_wr = 1'b0;
    if (!w[7]) begin
      if (w[3:1] == 3'd4) m_inte = w[0];
      if (w[3:1] == 3'd7) m_spare[1] = w[0];
      if (w[3:1] == 3'd6) m_spare[0] = w[0];
    end
    check(spare_out == m_spare, req, spare_out, m_spare);
    check(intr == (m_ibf & m_inte), req, intr, m_ibf & m_inte);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check({host_rdata, ibf, intr, spare_out} == 12'h000, "R1", {host_rdata, ibf, intr, spare_out}, 0);
    do_status("R1");

    // R3 exact timing of buffer-full
    pin_data = 8'hA5; stb_n = 1'b0;
    repeat (4) tick();
    stb_n = 1'b1; pin_data = 8'h3C;
    tick(); tick();
    check(ibf == 1'b0, "R3", ibf, 0);
    tick();
    check(ibf == 1'b1, "R3", ibf, 1);
    m_latch = 8'hA5; m_ibf = 1'b1;
    repeat (3) tick();
    check(ibf == 1'b1, "R3", ibf, 1);
    check(intr == 1'b0, "R5", intr, 0);
    do_status("R9");
    do_read("R2");

    // R6 enable, intr after data present
    do_strobe(8'h5A, "R3");
    do_bsr(8'h09, "R6");
    check(intr == 1'b1, "R5", intr, 1);
    do_bsr(8'h08, "R6");
    check(intr == 1'b0, "R5", intr, 0);
    do_bsr(8'h09, "R6");
    do_bsr(8'h89, "R8");
    do_bsr(8'h05, "R8");
    do_bsr(8'h0F, "R7");
    do_bsr(8'h0D, "R7");
    do_status("R9");
    // R10 overwrite while full
    do_strobe(8'hC3, "R10");
    do_read("R10");
    check(intr == 1'b0, "R4", intr, 0);

    for (int i = 0; i < 300; i++) begin
      case ($urandom % 5)
        0, 1: do_strobe(8'($urandom), "R2");
        2: if (m_ibf) do_read("R4"); else do_status("R9");
        3: do_bsr({1'($urandom), 3'b000, 3'($urandom), 1'($urandom)}, "R6");
        default: do_status("R9");
      endcase
    end
    if (m_ibf) do_read("R4");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule